// File: doc/BRIEF.md
# HDMI PLL Divider Search Engine

This block turns a requested pixel clock (in kHz) into the settings a display PLL needs to drive an HDMI or DVI link. After a one-cycle `start` pulse, it first checks the rate against the ceiling for the selected link type. It then walks a fixed list of output dividers against three DCO centre frequencies, testing one divider and centre pair per clock. It keeps the pair with the smallest truncated deviation that lies inside an asymmetric window.

When the search is over, the engine does three things:
- It splits the chosen divider into three post-divider stages.
- It encodes those stages as small codes.
- It derives the integer and 15-bit fractional DCO words relative to a 24 MHz reference.

A one-cycle `done` pulse reports the result. It comes with a `fail` flag when the rate is too high or no pair qualifies. The caller holds the request inputs only for the start cycle. It reads the fields while `busy` is low.

Top module: `hdmi_pll_search`

## Requirements
- R1: In the cycle after `start` is sampled with `busy` low, a request whose `pixKhz` exceeds 300000 (when `hdmiMode`=1) or 165000 (when `hdmiMode`=0) reports `done`=1 with `fail`=1, and no search is made.
- R2: Link clock is 5·pixKhz. DCO = divider·link. Deviation d = floor(1000·|DCO−centre|/centre). The search starts with best = 60. A DCO strictly above a centre is taken if d<10 and d<best. A DCO at or below a centre is taken if d<best. The order is centres 8400000, 9000000, 9600000 kHz (outer loop), then the even dividers in ascending order 4,6,8,10,12,14,16,18,20,24,28,30,32,36,40,42,44,48,52,54,56,60,64,66,68,70,72,76,78,80,84,88,90,92,96,98 (inner loop). Only a strictly smaller d replaces the current choice.
- R3: Only when no even divider is taken are the odd dividers 3,5,7,9,15,21,35 searched, with the same rules and loop order.
- R4: If no divider in either list is taken, `done` rises with `fail`=1. On any failed result, `dcoInt`, `dcoFrac`, `qDiv`, `qMode`, `pCode`, `kCode` and `cfCode` are all 0.
- R5: The chosen divider D is split into stages a, b and c, each 1 unless a rule sets it.
  - For even D, with h = D/2, the first matching rule applies:
    - h∈{1,2,3,5}: a=2, c=h.
    - h even: a=2, b=h/2, c=2.
    - h multiple of 3: a=3, b=h/3, c=2.
    - h multiple of 7: a=7, b=h/7, c=2.
  - For odd D:
    - 3 and 9: a=3, c=D/3.
    - 5 and 7: a=D.
    - 15: a=3, c=5.
    - 21: a=7, c=3.
    - 35: a=7, c=5.
  - Outputs: `qDiv`=b and `qMode`=(b≠1). `pCode` encodes a as 1→0, 2→1, 3→2, 7→3. `kCode` encodes c as 1→0, 2→1, 3→2, 5→3.
- R6: `cfCode` is 0, 1 or 2 for the chosen centre 8400, 9000 or 9600 MHz.
- R7: `dcoInt` = floor(floor(DCO_kHz/1000)/24) for the chosen pair.
- R8: `dcoFrac` = floor((floor(DCO_kHz·32768/24) − dcoInt·1000·32768)/1000), kept to 15 bits.
- R9: `done` is a one-cycle pulse with `busy` low. The result fields change only in a `done` cycle and hold until the next result. `busy` is high during a search. A `start` while `busy` is high is ignored.
- R10: After reset, `done`, `fail` and `busy` are 0 and all result fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, sampled while idle |
| hdmiMode | input | 1 | 1 selects the HDMI rate ceiling, 0 the DVI ceiling |
| pixKhz | input | PIX_W | Pixel clock in kHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result strobe |
| fail | output | 1 | Result is a failure |
| dcoInt | output | 16 | DCO integer word |
| dcoFrac | output | FRAC_W | DCO fractional word |
| qDiv | output | 8 | Middle post-divider stage |
| qMode | output | 1 | Middle stage in use |
| pCode | output | 2 | First stage code |
| kCode | output | 2 | Last stage code |
| cfCode | output | 2 | Chosen centre frequency code |

## Verification
Most internal faults reach the ports only at the end of a request, because the best-so-far registers are hidden until `done`.

- A wrong candidate index, an off-by-one in the deviation limits or a broken tie rule shows as a wrong divider. The wrong divider then surfaces as wrong stage codes and DCO words. This happens about 110 cycles after `start` for an even result, or about 132 cycles for an odd one.
- A fault in the phase sequencing shows in two ways. An odd search may run when an even divider had already qualified. Or `fail` may be reported for a rate that has a valid pair.
- Rate-limit faults show in the very next cycle after `start`.

The requests are chosen so that each path is taken: even results, an odd-only result, in-range failures and both ceilings.

// File: rtl/hdmi_pll_pkg.sv
package hdmi_pll_pkg;

  localparam int EVEN_COUNT    = 36;
  localparam int ODD_COUNT     = 7;
  localparam int CENTRAL_COUNT = 3;
  localparam int DIV_W         = 7;
  localparam int IDX_W         = 6;
  localparam int CIDX_W        = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic              load;
    logic              eval;
    logic              publish;
    logic              failOut;
    logic              oddSel;
    logic [CIDX_W-1:0] cIdx;
    logic [IDX_W-1:0]  dIdx;
  } step_t;

  typedef struct packed {
    logic [DIV_W-1:0] p0;
    logic [DIV_W-1:0] p1;
    logic [DIV_W-1:0] p2;
  } stages_t;

  function automatic logic [DIV_W-1:0] evenDiv(input logic [IDX_W-1:0] i);
    case (i)
      6'd0:  return 7'd4;   6'd1:  return 7'd6;   6'd2:  return 7'd8;
      6'd3:  return 7'd10;  6'd4:  return 7'd12;  6'd5:  return 7'd14;
      6'd6:  return 7'd16;  6'd7:  return 7'd18;  6'd8:  return 7'd20;
      6'd9:  return 7'd24;  6'd10: return 7'd28;  6'd11: return 7'd30;
      6'd12: return 7'd32;  6'd13: return 7'd36;  6'd14: return 7'd40;
      6'd15: return 7'd42;  6'd16: return 7'd44;  6'd17: return 7'd48;
      6'd18: return 7'd52;  6'd19: return 7'd54;  6'd20: return 7'd56;
      6'd21: return 7'd60;  6'd22: return 7'd64;  6'd23: return 7'd66;
      6'd24: return 7'd68;  6'd25: return 7'd70;  6'd26: return 7'd72;
      6'd27: return 7'd76;  6'd28: return 7'd78;  6'd29: return 7'd80;
      6'd30: return 7'd84;  6'd31: return 7'd88;  6'd32: return 7'd90;
      6'd33: return 7'd92;  6'd34: return 7'd96;  6'd35: return 7'd98;
      default: return 7'd4;
    endcase
  endfunction

  function automatic logic [DIV_W-1:0] oddDiv(input logic [IDX_W-1:0] i);
    case (i)
      6'd0: return 7'd3;   6'd1: return 7'd5;   6'd2: return 7'd7;
      6'd3: return 7'd9;   6'd4: return 7'd15;  6'd5: return 7'd21;
      6'd6: return 7'd35;
      default: return 7'd3;
    endcase
  endfunction

  function automatic logic [31:0] centralKhz(input logic [CIDX_W-1:0] c);
    case (c)
      2'd0:    return 32'd8400000;
      2'd1:    return 32'd9000000;
      default: return 32'd9600000;
    endcase
  endfunction

  // deviation in tenths of a percent, truncated (centre given in MHz)
  function automatic logic [31:0] devUnits(input logic [31:0] diff,
                                           input logic [CIDX_W-1:0] c);
    case (c)
      2'd0:    return diff / 32'd8400;
      2'd1:    return diff / 32'd9000;
      default: return diff / 32'd9600;
    endcase
  endfunction

  function automatic stages_t factorDiv(input logic [DIV_W-1:0] d);
    int dv, h, a, b, c;
    dv = int'(d);
    h  = dv / 2;
    a  = 1; b = 1; c = 1;
    if (dv % 2 == 0) begin
      if (h == 1 || h == 2 || h == 3 || h == 5) begin a = 2; c = h; end
      else if (h % 2 == 0) begin a = 2; b = h / 2; c = 2; end
      else if (h % 3 == 0) begin a = 3; b = h / 3; c = 2; end
      else if (h % 7 == 0) begin a = 7; b = h / 7; c = 2; end
    end else begin
      case (dv)
        3, 9:    begin a = 3; c = dv / 3; end
        5, 7:    a = dv;
        15:      begin a = 3; c = 5; end
        21:      begin a = 7; c = 3; end
        35:      begin a = 7; c = 5; end
        default: ;
      endcase
    end
    return '{p0: DIV_W'(a), p1: DIV_W'(b), p2: DIV_W'(c)};
  endfunction

  function automatic logic [1:0] pEnc(input logic [DIV_W-1:0] v);
    case (v)
      7'd2:    return 2'd1;
      7'd3:    return 2'd2;
      7'd7:    return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [1:0] kEnc(input logic [DIV_W-1:0] v);
    case (v)
      7'd2:    return 2'd1;
      7'd3:    return 2'd2;
      7'd5:    return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/hdmi_pll_ctrl.sv
module hdmi_pll_ctrl
  import hdmi_pll_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  start,
  input  logic  overLimit,
  input  logic  found,
  output step_t step,
  output logic  busy
);

  typedef enum logic [1:0] {S_IDLE, S_SEARCH, S_CHECK} state_t;

  state_t            state, stateN;
  logic [CIDX_W-1:0] cIdx, cIdxN;
  logic [IDX_W-1:0]  dIdx, dIdxN;
  logic              oddSel, oddSelN;
  logic              lastDiv;

  assign lastDiv = oddSel ? (dIdx == IDX_W'(ODD_COUNT - 1))
                          : (dIdx == IDX_W'(EVEN_COUNT - 1));

  always_comb begin
    step        = '0;
    step.oddSel = oddSel;
    step.cIdx   = cIdx;
    step.dIdx   = dIdx;
    stateN      = state;
    cIdxN       = cIdx;
    dIdxN       = dIdx;
    oddSelN     = oddSel;
    case (state)
      S_IDLE: begin
        if (start) begin
          if (overLimit) begin
            step.publish = 1'b1;
            step.failOut = 1'b1;
          end else begin
            step.load = 1'b1;
            stateN    = S_SEARCH;
            cIdxN     = '0;
            dIdxN     = '0;
            oddSelN   = 1'b0;
          end
        end
      end
      S_SEARCH: begin
        step.eval = 1'b1;
        if (lastDiv) begin
          dIdxN = '0;
          if (cIdx == CIDX_W'(CENTRAL_COUNT - 1)) begin
            cIdxN  = '0;
            stateN = S_CHECK;
          end else begin
            cIdxN = cIdx + 1'b1;
          end
        end else begin
          dIdxN = dIdx + 1'b1;
        end
      end
      S_CHECK: begin
        if (found) begin
          step.publish = 1'b1;
          stateN       = S_IDLE;
        end else if (!oddSel) begin
          oddSelN = 1'b1;
          stateN  = S_SEARCH;
        end else begin
          step.publish = 1'b1;
          step.failOut = 1'b1;
          stateN       = S_IDLE;
        end
      end
      default: stateN = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      cIdx   <= '0;
      dIdx   <= '0;
      oddSel <= 1'b0;
    end else begin
      state  <= stateN;
      cIdx   <= cIdxN;
      dIdx   <= dIdxN;
      oddSel <= oddSelN;
    end
  end

  assign busy = (state != S_IDLE);

endmodule

// File: rtl/hdmi_pll_dp.sv
module hdmi_pll_dp
  import hdmi_pll_pkg::*;
#(
  parameter int PIX_W        = 20,
  parameter int HDMI_MAX_KHZ = 300000,
  parameter int DVI_MAX_KHZ  = 165000,
  parameter int FRAC_W       = 15,
  parameter int REF_MHZ      = 24,
  parameter int BEST_INIT    = 60,
  parameter int ABOVE_LIMIT  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  step_t             step,
  input  logic [PIX_W-1:0]  pixKhz,
  input  logic              hdmiMode,
  output logic              overLimit,
  output logic              found,
  output logic              done,
  output logic              fail,
  output logic [15:0]       dcoInt,
  output logic [FRAC_W-1:0] dcoFrac,
  output logic [7:0]        qDiv,
  output logic              qMode,
  output logic [1:0]        pCode,
  output logic [1:0]        kCode,
  output logic [1:0]        cfCode
);

  localparam int DEV_W  = $clog2(BEST_INIT + 1);
  localparam int WIDE_W = 32 + FRAC_W + 1;

  logic [PIX_W-1:0]  pixReg;
  logic [DEV_W-1:0]  bestDev;
  logic [DIV_W-1:0]  bestDiv;
  logic [CIDX_W-1:0] bestC;
  logic              foundR;

  // request ceiling check, straight from the inputs
  assign overLimit = hdmiMode ? (32'(pixKhz) > 32'(HDMI_MAX_KHZ))
                              : (32'(pixKhz) > 32'(DVI_MAX_KHZ));

  // candidate evaluation
  logic [31:0]      linkKhz, dco, cf, diff, dev;
  logic [DIV_W-1:0] candDiv;
  logic             above, accept;

  assign linkKhz = 32'(pixReg) * 32'd5;
  assign candDiv = step.oddSel ? oddDiv(step.dIdx) : evenDiv(step.dIdx);
  assign dco     = 32'(candDiv) * linkKhz;
  assign cf      = centralKhz(step.cIdx);
  assign above   = dco > cf;
  assign diff    = above ? (dco - cf) : (cf - dco);
  assign dev     = devUnits(diff, step.cIdx);
  assign accept  = (dev < 32'(bestDev)) && (!above || dev < 32'(ABOVE_LIMIT));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixReg  <= '0;
      bestDev <= DEV_W'(BEST_INIT);
      bestDiv <= '0;
      bestC   <= '0;
      foundR  <= 1'b0;
    end else if (step.load) begin
      pixReg  <= pixKhz;
      bestDev <= DEV_W'(BEST_INIT);
      bestDiv <= '0;
      bestC   <= '0;
      foundR  <= 1'b0;
    end else if (step.eval && accept) begin
      bestDev <= DEV_W'(dev);
      bestDiv <= candDiv;
      bestC   <= step.cIdx;
      foundR  <= 1'b1;
    end
  end

  assign found = foundR;

  // result derivation from the winning pair
  logic [31:0]       dcoSel, intWide;
  logic [WIDE_W-1:0] scaled, fracWide;
  stages_t           stg;

  assign dcoSel   = 32'(bestDiv) * linkKhz;
  assign intWide  = (dcoSel / 32'd1000) / 32'(REF_MHZ);
  assign scaled   = (WIDE_W'(dcoSel) << FRAC_W) / WIDE_W'(REF_MHZ);
  assign fracWide = (scaled - WIDE_W'(intWide) * WIDE_W'(1000) * (WIDE_W'(1) << FRAC_W))
                    / WIDE_W'(1000);
  assign stg      = factorDiv(bestDiv);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done    <= 1'b0;
      fail    <= 1'b0;
      dcoInt  <= '0;
      dcoFrac <= '0;
      qDiv    <= '0;
      qMode   <= 1'b0;
      pCode   <= '0;
      kCode   <= '0;
      cfCode  <= '0;
    end else begin
      done <= step.publish;
      if (step.publish) begin
        fail <= step.failOut;
        if (step.failOut) begin
          dcoInt  <= '0;
          dcoFrac <= '0;
          qDiv    <= '0;
          qMode   <= 1'b0;
          pCode   <= '0;
          kCode   <= '0;
          cfCode  <= '0;
        end else begin
          dcoInt  <= 16'(intWide);
          dcoFrac <= FRAC_W'(fracWide);
          qDiv    <= 8'(stg.p1);
          qMode   <= (stg.p1 != 7'd1);
          pCode   <= pEnc(stg.p0);
          kCode   <= kEnc(stg.p2);
          cfCode  <= bestC;
        end
      end
    end
  end

endmodule

// File: rtl/hdmi_pll_search.sv
module hdmi_pll_search
  import hdmi_pll_pkg::*;
#(
  parameter int PIX_W        = 20,
  parameter int HDMI_MAX_KHZ = 300000,
  parameter int DVI_MAX_KHZ  = 165000,
  parameter int FRAC_W       = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              hdmiMode,
  input  logic [PIX_W-1:0]  pixKhz,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [15:0]       dcoInt,
  output logic [FRAC_W-1:0] dcoFrac,
  output logic [7:0]        qDiv,
  output logic              qMode,
  output logic [1:0]        pCode,
  output logic [1:0]        kCode,
  output logic [1:0]        cfCode
);

  step_t step;
  logic  overLimit;
  logic  found;

  hdmi_pll_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .overLimit (overLimit),
    .found     (found),
    .step      (step),
    .busy      (busy)
  );

  hdmi_pll_dp #(
    .PIX_W        (PIX_W),
    .HDMI_MAX_KHZ (HDMI_MAX_KHZ),
    .DVI_MAX_KHZ  (DVI_MAX_KHZ),
    .FRAC_W       (FRAC_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .step      (step),
    .pixKhz    (pixKhz),
    .hdmiMode  (hdmiMode),
    .overLimit (overLimit),
    .found     (found),
    .done      (done),
    .fail      (fail),
    .dcoInt    (dcoInt),
    .dcoFrac   (dcoFrac),
    .qDiv      (qDiv),
    .qMode     (qMode),
    .pCode     (pCode),
    .kCode     (kCode),
    .cfCode    (cfCode)
  );

endmodule

// File: rtl/hdmi_pll_search_chk.sv
module hdmi_pll_search_chk #(
  parameter int PIX_W        = 20,
  parameter int HDMI_MAX_KHZ = 300000
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             hdmiMode,
  input logic [PIX_W-1:0] pixKhz,
  input logic             busy,
  input logic             done,
  input logic             fail,
  input logic [15:0]      dcoInt,
  input logic [7:0]       qDiv,
  input logic             qMode,
  input logic [1:0]       cfCode
);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  idle_at_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(dcoInt) || !$stable(cfCode) || !$stable(fail)) |-> done);

  // R1
  hdmi_ceiling_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && hdmiMode && (32'(pixKhz) > 32'(HDMI_MAX_KHZ))) |=> (done && fail));

  // R5
  qmode_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !fail) |-> (qMode == (qDiv != 8'd1)));

  // R6
  cf_code_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !fail) |-> (cfCode != 2'd3));

  // R4
  fail_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && fail) |-> (dcoInt == 16'd0 && qDiv == 8'd0 && cfCode == 2'd0));

endmodule

bind hdmi_pll_search hdmi_pll_search_chk #(
  .PIX_W        (PIX_W),
  .HDMI_MAX_KHZ (HDMI_MAX_KHZ)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .hdmiMode (hdmiMode),
  .pixKhz   (pixKhz),
  .busy     (busy),
  .done     (done),
  .fail     (fail),
  .dcoInt   (dcoInt),
  .qDiv     (qDiv),
  .qMode    (qMode),
  .cfCode   (cfCode)
);

// File: tb/hdmi_pll_search_bench.sv
`timescale 1ns/1ps
module hdmi_pll_search_bench;

  localparam int PIX_W  = 20;
  localparam int FRAC_W = 15;

  logic              clk = 1'b0;
  logic              rstN;
  logic              start;
  logic              hdmiMode;
  logic [PIX_W-1:0]  pixKhz;
  logic              busy, done, fail, qMode;
  logic [15:0]       dcoInt;
  logic [FRAC_W-1:0] dcoFrac;
  logic [7:0]        qDiv;
  logic [1:0]        pCode, kCode, cfCode;

  always #4 clk = ~clk;

  hdmi_pll_search u_hdmi_pll_search (
    .clk(clk), .rstN(rstN), .start(start), .hdmiMode(hdmiMode), .pixKhz(pixKhz),
    .busy(busy), .done(done), .fail(fail), .dcoInt(dcoInt), .dcoFrac(dcoFrac),
    .qDiv(qDiv), .qMode(qMode), .pCode(pCode), .kCode(kCode), .cfCode(cfCode)
  );

  typedef struct {
    bit    fail;
    int    dInt;
    int    dFrac;
    int    q;
    bit    qm;
    int    p;
    int    k;
    int    cf;
    string tag;
  } exp_t;

  exp_t expq[$];
  int   checks = 0;
  int   failures = 0;
  bit   prevDone = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // reference computed from the requirement text
  function automatic exp_t model(input int pix, input bit hdmi, input string tag);
    exp_t   e;
    int     evenL[36] = '{4,6,8,10,12,14,16,18,20,24,28,30,32,36,40,42,44,48,
                          52,54,56,60,64,66,68,70,72,76,78,80,84,88,90,92,96,98};
    int     oddL[7]   = '{3,5,7,9,15,21,35};
    longint cfs[3]    = '{64'd8400000, 64'd9000000, 64'd9600000};
    longint link, dco, dev, scaled;
    int     best, chD, chC, h, a, b, c;
    bit     fnd;
    e.tag = tag; e.fail = 0; e.dInt = 0; e.dFrac = 0; e.q = 0; e.qm = 0;
    e.p = 0; e.k = 0; e.cf = 0;
    if (pix > (hdmi ? 300000 : 165000)) begin e.fail = 1; return e; end
    best = 60; fnd = 0; chD = 0; chC = 0;
    link = longint'(pix) * 5;
    for (int par = 0; par < 2 && !fnd; par++) begin
      for (int ci = 0; ci < 3; ci++) begin
        for (int j = 0; j < (par ? 7 : 36); j++) begin
          int dv;
          dv  = par ? oddL[j] : evenL[j];
          dco = longint'(dv) * link;
          if (dco > cfs[ci]) begin
            dev = (dco - cfs[ci]) * 1000 / cfs[ci];
            if (dev < 10 && dev < best) begin best = int'(dev); chD = dv; chC = ci; fnd = 1; end
          end else begin
            dev = (cfs[ci] - dco) * 1000 / cfs[ci];
            if (dev < best) begin best = int'(dev); chD = dv; chC = ci; fnd = 1; end
          end
        end
      end
    end
    if (!fnd) begin e.fail = 1; return e; end
    a = 1; b = 1; c = 1; h = chD / 2;
    if (chD % 2 == 0) begin
      if (h == 1 || h == 2 || h == 3 || h == 5) begin a = 2; c = h; end
      else if (h % 2 == 0) begin a = 2; b = h / 2; c = 2; end
      else if (h % 3 == 0) begin a = 3; b = h / 3; c = 2; end
      else if (h % 7 == 0) begin a = 7; b = h / 7; c = 2; end
    end else if (chD == 3 || chD == 9) begin a = 3; c = chD / 3; end
    else if (chD == 5 || chD == 7) a = chD;
    else if (chD == 15) begin a = 3; c = 5; end
    else if (chD == 21) begin a = 7; c = 3; end
    else if (chD == 35) begin a = 7; c = 5; end
    e.q  = b;
    e.qm = (b != 1);
    e.p  = (a == 1) ? 0 : (a == 2) ? 1 : (a == 3) ? 2 : 3;
    e.k  = (c == 1) ? 0 : (c == 2) ? 1 : (c == 3) ? 2 : 3;
    e.cf = chC;
    dco     = longint'(chD) * link;
    e.dInt  = int'((dco / 1000) / 24);
    scaled  = dco * 32768 / 24;
    e.dFrac = int'(((scaled - longint'(e.dInt) * 1000 * 32768) / 1000) % 32768);
    return e;
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (prevDone) check(done == 1'b0, "R9", "done width", done, 0);
      if (done) begin
        if (expq.size() == 0) begin
          check(1'b0, "R9", "unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = expq.pop_front();
          check(fail == e.fail, e.tag, "fail", fail, e.fail);
          check(dcoInt == 16'(e.dInt), "R7", "dcoInt", dcoInt, e.dInt);
          check(dcoFrac == FRAC_W'(e.dFrac), "R8", "dcoFrac", dcoFrac, e.dFrac);
          check(qDiv == 8'(e.q) && qMode == e.qm && pCode == 2'(e.p) && kCode == 2'(e.k),
                "R5", "stages q/qm/p/k",
                {qDiv, 3'b0, qMode, 2'b0, pCode, 2'b0, kCode},
                {8'(e.q), 3'b0, e.qm, 2'b0, 2'(e.p), 2'b0, 2'(e.k)});
          check(cfCode == 2'(e.cf), "R6", "cfCode", cfCode, e.cf);
        end
      end
      prevDone = done;
    end
  end

  task automatic runReq(input int pix, input bit hdmi, input string tag);
    expq.push_back(model(pix, hdmi, tag));
    @(negedge clk);
    pixKhz = PIX_W'(pix); hdmiMode = hdmi; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] heldInt;
    logic [1:0]  heldCf;
    rstN = 1'b0; start = 1'b0; hdmiMode = 1'b1; pixKhz = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10
    check(done == 0 && fail == 0 && busy == 0, "R10", "flags after reset",
          {done, fail, busy}, 0);
    check(dcoInt == 0 && dcoFrac == 0 && qDiv == 0 && cfCode == 0 && pCode == 0 && kCode == 0,
          "R10", "fields after reset", dcoInt, 0);

    runReq(25175, 1'b1, "R2");
    runReq(27000, 1'b1, "R2");
    runReq(74250, 1'b1, "R2");
    runReq(148500, 1'b1, "R2");
    runReq(297000, 1'b1, "R2");
    runReq(300000, 1'b1, "R2");
    runReq(165000, 1'b0, "R2");
    runReq(257000, 1'b1, "R3");
    runReq(300001, 1'b1, "R1");
    runReq(165001, 1'b0, "R1");
    runReq(1000, 1'b1, "R4");
    runReq(0, 1'b0, "R4");

    // R9: hold between results
    runReq(148500, 1'b1, "R2");
    heldInt = dcoInt; heldCf = cfCode;
    repeat (6) @(negedge clk);
    check(dcoInt == heldInt && cfCode == heldCf && done == 0, "R9", "hold after done",
          dcoInt, heldInt);

    // R9: start while busy is ignored
    expq.push_back(model(74250, 1'b1, "R9"));
    @(negedge clk);
    pixKhz = PIX_W'(74250); hdmiMode = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    check(busy == 1'b1, "R9", "busy during search", busy, 1);
    pixKhz = PIX_W'(1000); hdmiMode = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0; pixKhz = '0;
    while (!done) @(negedge clk);

    repeat (4) @(negedge clk);
    check(expq.size() == 0, "R9", "pending results", expq.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule